// File: doc/BRIEF.md
# Partitioned Fully-Associative Translation Buffer

This block is a small, fully associative address translation buffer. Every slot holds five tag fields and a physical base:

- a virtual base;
- one of four page sizes;
- a partition number;
- a context number;
- a flag that marks the mapping as real-mode.

A lookup compares the presented address and keys against every slot in the same cycle. On a hit, the block returns the slot number and the physical address, which is the stored physical page joined with the in-page offset.

Writing a new mapping first removes every valid mapping that would alias it. A mapping aliases the new one when it has the same partition and the same real flag, its range overlaps, and its context matches; the context comparison is skipped for real-mode mappings. The new mapping then goes into one of two places:

- a caller-chosen slot;
- a victim picked round-robin from the last automatically replaced slot, skipping locked slots.

A single command clears the whole table. The block also keeps a live count of slots that have been hit since they were written.

Only one of insert, lookup and clear is meant to be asserted in a cycle. If several are asserted, clear wins over insert, and insert wins over lookup.

Top module: `part_tlb`

## Requirements
- R1: After reset, the following hold: no slot is valid, no slot is locked or used, `used_count` is 0, `ins_done` is 0, and the round-robin pointer is 0, so the first automatic insert lands in slot 1.
- R2: A lookup hits a slot only when all of these hold: the slot is valid; the real flag and partition are equal; the context is equal unless `lk_real` is 1; and base <= address <= base + size - 1. On a hit, `lk_idx` is the slot and `lk_pa` is the stored physical base with its low page bits replaced by the address's low page bits. `lk_hit` is combinational.
- R3: The page size code maps to an offset width: 0 is 8 KiB (13 bits), 1 is 64 KiB (16), 2 is 4 MiB (22) and 3 is 256 MiB (28).
- R4: A lookup hit sets the slot's used flag. `used_count` rises by one only when that flag was clear, and it is visible after the clock edge.
- R5: An insert invalidates every valid slot that meets all of these conditions: same real flag; same partition; existing base < new base + new size - 1; existing base + existing size - 1 >= new base; and either the new mapping is real or the contexts are equal. Each such slot that was used lowers `used_count` by one.
- R6: An automatic insert (`ins_use_idx`=0) takes the first unlocked slot found by stepping upward from the pointer plus one, wrapping at the top. That slot becomes the new pointer.
- R7: If every slot is locked, an automatic insert writes the last slot and the pointer is left unchanged.
- R8: An insert with `ins_use_idx`=1 writes slot `ins_idx` directly and leaves the pointer unchanged.
- R9: If the slot being written was valid and used, and was not already removed as a conflict, `used_count` drops by one. A freshly written slot is valid and unused, and it takes its lock bit from `ins_lock`.
- R10: `inv_all` clears the valid, used and lock bits of every slot and sets `used_count` to 0 at the next edge. The pointer is kept.
- R11: An insert with `ins_pte_valid`=0 changes no slot, no count and no pointer, and gives no `ins_done`.
- R12: An accepted insert finishes in its cycle. `ins_done` is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear the whole table |
| ins_req | input | 1 | Insert command |
| ins_pte_valid | input | 1 | Incoming mapping is valid; if 0, the insert is dropped |
| ins_use_idx | input | 1 | Use `ins_idx` instead of the round-robin victim |
| ins_idx | input | IW | Explicit target slot |
| ins_va | input | AW | Virtual base of the new mapping |
| ins_pa | input | AW | Physical base of the new mapping |
| ins_size | input | 2 | Page size code |
| ins_part | input | PW | Partition number |
| ins_ctx | input | CW | Context number |
| ins_real | input | 1 | Real-mode mapping |
| ins_lock | input | 1 | Lock the new slot against round-robin replacement |
| ins_done | output | 1 | Insert completed (one-cycle pulse) |
| lk_req | input | 1 | Lookup command |
| lk_va | input | AW | Lookup address |
| lk_part | input | PW | Lookup partition |
| lk_ctx | input | CW | Lookup context |
| lk_real | input | 1 | Lookup is real-mode |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IW | Slot that hit |
| lk_pa | output | AW | Translated physical address |
| used_count | output | CNTW | Number of valid slots hit since they were written |

## Verification
A bad valid, lock or key bit inside the table can only be seen through later lookups and inserts. It shows up on the next lookup as a missing or extra `lk_hit` or a wrong `lk_idx`. A bad round-robin pointer shows up only after the following automatic insert, when a later lookup finds the new mapping in an unexpected slot. Bookkeeping errors in the used flags show up in `used_count` one cycle after the hit, demap or overwrite that caused them, so every step's count is compared right after its edge.

// File: rtl/part_tlb.sv
module part_tlb #(
  parameter int ENTRIES = 16,
  parameter int AW      = 64,
  parameter int PW      = 8,
  parameter int CW      = 13,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CNTW   = $clog2(ENTRIES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_all,
  input  logic            ins_req,
  input  logic            ins_pte_valid,
  input  logic            ins_use_idx,
  input  logic [IW-1:0]   ins_idx,
  input  logic [AW-1:0]   ins_va,
  input  logic [AW-1:0]   ins_pa,
  input  logic [1:0]      ins_size,
  input  logic [PW-1:0]   ins_part,
  input  logic [CW-1:0]   ins_ctx,
  input  logic            ins_real,
  input  logic            ins_lock,
  output logic            ins_done,
  input  logic            lk_req,
  input  logic [AW-1:0]   lk_va,
  input  logic [PW-1:0]   lk_part,
  input  logic [CW-1:0]   lk_ctx,
  input  logic            lk_real,
  output logic            lk_hit,
  output logic [IW-1:0]   lk_idx,
  output logic [AW-1:0]   lk_pa,
  output logic [CNTW-1:0] used_count
);

  function automatic logic [AW-1:0] pg_mask(input logic [1:0] s);
    case (s)
      2'd0:    return (AW'(1) << 13) - AW'(1);
      2'd1:    return (AW'(1) << 16) - AW'(1);
      2'd2:    return (AW'(1) << 22) - AW'(1);
      default: return (AW'(1) << 28) - AW'(1);
    endcase
  endfunction

  logic [AW-1:0] base_q [ENTRIES];
  logic [AW-1:0] pa_q   [ENTRIES];
  logic [1:0]    sz_q   [ENTRIES];
  logic [PW-1:0] part_q [ENTRIES];
  logic [CW-1:0] ctx_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q, used_q, lock_q, real_q;
  logic [IW-1:0]   ptr_q;
  logic [CNTW-1:0] cnt_q;

  logic ins_go, lk_go, all_locked;
  logic [ENTRIES-1:0] conflict, hit_vec;
  logic [IW-1:0] victim, slot, hidx;
  logic [CNTW-1:0] dec;
  logic [AW:0] new_last;

  assign ins_go   = ins_req && ins_pte_valid && !inv_all;
  assign lk_go    = lk_req && !ins_req && !inv_all;
  assign new_last = {1'b0, ins_va} + {1'b0, pg_mask(ins_size)};

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [AW:0] ex_last;
      ex_last = {1'b0, base_q[i]} + {1'b0, pg_mask(sz_q[i])};
      conflict[i] = valid_q[i] && (real_q[i] == ins_real) && (part_q[i] == ins_part) &&
                    ({1'b0, base_q[i]} < new_last) && (ex_last >= {1'b0, ins_va}) &&
                    (ins_real || ctx_q[i] == ins_ctx);
      hit_vec[i]  = valid_q[i] && (real_q[i] == lk_real) && (part_q[i] == lk_part) &&
                    (lk_real || ctx_q[i] == lk_ctx) &&
                    ({1'b0, lk_va} >= {1'b0, base_q[i]}) && ({1'b0, lk_va} <= ex_last);
    end
  end

  always_comb begin
    victim     = IW'(ENTRIES - 1);
    all_locked = 1'b1;
    for (int k = ENTRIES; k >= 1; k--) begin
      int c;
      c = (int'(ptr_q) + k) % ENTRIES;
      if (!lock_q[c]) begin
        victim     = IW'(c);
        all_locked = 1'b0;
      end
    end
  end

  assign slot = ins_use_idx ? ins_idx : victim;

  always_comb begin
    dec = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid_q[i] && used_q[i] && (conflict[i] || slot == IW'(i)))
        dec = dec + CNTW'(1);
  end

  always_comb begin
    hidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hidx = IW'(i);
  end

  assign lk_hit     = lk_req && |hit_vec;
  assign lk_idx     = hidx;
  assign lk_pa      = (pa_q[hidx] & ~pg_mask(sz_q[hidx])) | (lk_va & pg_mask(sz_q[hidx]));
  assign used_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      used_q   <= '0;
      lock_q   <= '0;
      real_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      ins_done <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        pa_q[i]   <= '0;
        sz_q[i]   <= '0;
        part_q[i] <= '0;
        ctx_q[i]  <= '0;
      end
    end else begin
      ins_done <= ins_go;
      if (inv_all) begin
        valid_q <= '0;
        used_q  <= '0;
        lock_q  <= '0;
        cnt_q   <= '0;
      end else if (ins_go) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (slot == IW'(i)) begin
            valid_q[i] <= 1'b1;
            used_q[i]  <= 1'b0;
            lock_q[i]  <= ins_lock;
            real_q[i]  <= ins_real;
            base_q[i]  <= ins_va;
            pa_q[i]    <= ins_pa;
            sz_q[i]    <= ins_size;
            part_q[i]  <= ins_part;
            ctx_q[i]   <= ins_ctx;
          end else if (conflict[i]) begin
            valid_q[i] <= 1'b0;
            used_q[i]  <= 1'b0;
          end
        end
        if (!ins_use_idx && !all_locked) ptr_q <= victim;
        cnt_q <= cnt_q - dec;
      end else if (lk_go && |hit_vec) begin
        used_q[hidx] <= 1'b1;
        if (!used_q[hidx]) cnt_q <= cnt_q + CNTW'(1);
      end
    end
  end

  a_r4_count_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
    used_count == CNTW'($countones(used_q & valid_q)));

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r4_hit_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_go && lk_hit) |=> used_q[$past(lk_idx)]);

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (used_count == '0 && valid_q == '0 && lock_q == '0));

  a_r11_invalid_pte_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_pte_valid && !inv_all && !lk_req) |=>
      (!ins_done && $stable(valid_q) && $stable(used_count)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && ins_pte_valid && !inv_all) |=> ins_done);

  a_r7_all_locked_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_go && !ins_use_idx && (&lock_q)) |=> (valid_q[ENTRIES-1] && $stable(ptr_q)));

endmodule

// File: tb/part_tlb_tb_top.sv
`timescale 1ns/1ps
module part_tlb_tb_top;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic inv_all = 0, ins_req = 0, ins_pte_valid = 0, ins_use_idx = 0;
  logic [3:0] ins_idx = '0;
  logic [AW-1:0] ins_va = '0, ins_pa = '0, lk_va = '0;
  logic [1:0] ins_size = '0;
  logic [7:0] ins_part = '0, lk_part = '0;
  logic [12:0] ins_ctx = '0, lk_ctx = '0;
  logic ins_real = 0, ins_lock = 0, lk_req = 0, lk_real = 0;
  logic ins_done, lk_hit;
  logic [3:0] lk_idx;
  logic [AW-1:0] lk_pa;
  logic [4:0] used_count;

  part_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .ins_req(ins_req), .ins_pte_valid(ins_pte_valid), .ins_use_idx(ins_use_idx),
    .ins_idx(ins_idx), .ins_va(ins_va), .ins_pa(ins_pa), .ins_size(ins_size),
    .ins_part(ins_part), .ins_ctx(ins_ctx), .ins_real(ins_real), .ins_lock(ins_lock),
    .ins_done(ins_done), .lk_req(lk_req), .lk_va(lk_va), .lk_part(lk_part),
    .lk_ctx(lk_ctx), .lk_real(lk_real), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_pa(lk_pa), .used_count(used_count)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_ins(input logic [31:0] va, input logic [1:0] sz, input logic [7:0] pt,
                        input logic [12:0] cx, input logic rl, input logic lk,
                        input logic ui, input logic [3:0] ix, input logic pv,
                        input logic [4:0] ecnt, input string req);
    @(negedge clk);
    ins_req = 1; ins_pte_valid = pv; ins_use_idx = ui; ins_idx = ix;
    ins_va = {32'h0, va}; ins_pa = {8'hA5, 24'h0, va}; ins_size = sz;
    ins_part = pt; ins_ctx = cx; ins_real = rl; ins_lock = lk;
    @(posedge clk); #1;
    ins_req = 0;
    chk(ins_done == pv, "R12", "ins_done", 64'(ins_done), 64'(pv));
    chk(used_count == ecnt, req, "used_count after insert", 64'(used_count), 64'(ecnt));
  endtask

  task automatic do_look(input logic [31:0] va, input logic [7:0] pt, input logic [12:0] cx,
                         input logic rl, input logic eh, input logic [3:0] ei,
                         input logic [4:0] ecnt, input string req);
    logic [63:0] epa;
    @(negedge clk);
    lk_req = 1; lk_va = {32'h0, va}; lk_part = pt; lk_ctx = cx; lk_real = rl;
    #1;
    chk(lk_hit == eh, req, "lk_hit", 64'(lk_hit), 64'(eh));
    if (eh) begin
      epa = {8'hA5, 24'h0, va};
      chk(lk_idx == ei, req, "lk_idx", 64'(lk_idx), 64'(ei));
      chk(lk_pa == epa, req, "lk_pa", lk_pa, epa);
    end
    @(posedge clk); #1;
    lk_req = 0;
    chk(used_count == ecnt, req, "used_count after lookup", 64'(used_count), 64'(ecnt));
  endtask

  task automatic do_inv();
    @(negedge clk);
    inv_all = 1;
    @(posedge clk); #1;
    inv_all = 0;
    chk(used_count == 0, "R10", "used_count after clear", 64'(used_count), 64'(0));
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] va;
    logic [1:0]  sz;
    logic [7:0]  pt;
    logic [12:0] cx;
    logic        rl;
    logic        ui;
    logic [3:0]  ix;
    logic        pv;
    logic        eh;
    logic [3:0]  ei;
    logic [4:0]  ec;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h0000_2000, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd0},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd1,  5'd1},
    '{2'd1, 32'h0000_3fff, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd1,  5'd1},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd6,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd2, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd5,  1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h0000_4000, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd0, 32'h0001_0000, 2'd1, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h0001_fff0, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd2,  5'd2},
    '{2'd0, 32'h0000_0000, 2'd1, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd3,  5'd2},
    '{2'd0, 32'h0000_0000, 2'd1, 8'd1, 13'd9,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd2},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd9,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd4,  5'd3},
    '{2'd0, 32'h0000_0000, 2'd0, 8'd1, 13'd0,  1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd3},
    '{2'd1, 32'h0000_0100, 2'd0, 8'd1, 13'd77, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd5,  5'd4},
    '{2'd0, 32'h0000_1000, 2'd0, 8'd1, 13'd3,  1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd3},
    '{2'd1, 32'h0000_0100, 2'd0, 8'd1, 13'd0,  1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd3},
    '{2'd1, 32'h0000_1100, 2'd0, 8'd1, 13'd0,  1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd6,  5'd4},
    '{2'd0, 32'h0004_0000, 2'd0, 8'd1, 13'd5,  1'b0, 1'b1, 4'd2, 1'b1, 1'b0, 4'd0,  5'd3},
    '{2'd1, 32'h0001_fff0, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd3},
    '{2'd1, 32'h0004_0010, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd2,  5'd4},
    '{2'd0, 32'h0008_0000, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0,  5'd4},
    '{2'd1, 32'h0008_0000, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd4},
    '{2'd2, 32'h0000_0000, 2'd0, 8'd0, 13'd0,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd0},
    '{2'd1, 32'h0000_2abc, 2'd0, 8'd1, 13'd5,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd0},
    '{2'd0, 32'h0040_0000, 2'd2, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd0},
    '{2'd1, 32'h007f_fffc, 2'd0, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd7,  5'd1},
    '{2'd0, 32'h1000_0000, 2'd3, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd1},
    '{2'd1, 32'h1fff_fff0, 2'd0, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd8,  5'd2},
    '{2'd1, 32'h2000_0000, 2'd0, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd2},
    '{2'd1, 32'h0080_0000, 2'd0, 8'd4, 13'd1,  1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0,  5'd2}
  };

  // Table coverage: R2 keys/range, R3 sizes, R4 count, R5 demap, R6 pointer, R8 explicit, R9 overwrite, R11 dropped insert
  localparam string VREQ [NV] = '{
    "R6", "R4", "R2", "R2", "R2", "R2", "R2", "R3", "R4", "R5",
    "R5", "R5", "R4", "R6", "R2", "R5", "R5", "R2", "R9", "R8",
    "R8", "R11", "R11", "R10", "R10", "R3", "R3", "R3", "R3", "R3", "R3"
  };

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(used_count == 0, "R1", "used_count", 64'(used_count), 64'(0));
    chk(ins_done == 0, "R1", "ins_done", 64'(ins_done), 64'(0));
    do_look(32'h0, 8'd0, 13'd0, 1'b0, 1'b0, 4'd0, 5'd0, "R1");
    do_look(32'h0, 8'd0, 13'd0, 1'b1, 1'b0, 4'd0, 5'd0, "R1");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        2'd0: do_ins(VEC[v].va, VEC[v].sz, VEC[v].pt, VEC[v].cx, VEC[v].rl, 1'b0,
                     VEC[v].ui, VEC[v].ix, VEC[v].pv, VEC[v].ec, VREQ[v]);
        2'd1: do_look(VEC[v].va, VEC[v].pt, VEC[v].cx, VEC[v].rl, VEC[v].eh,
                      VEC[v].ei, VEC[v].ec, VREQ[v]);
        default: do_inv();
      endcase
    end

    // R6 locked slot skipped: pointer is 8, slot 9 locked, next auto lands in 10
    do_inv();
    do_ins(32'h0, 2'd0, 8'd3, 13'd1, 1'b0, 1'b1, 1'b1, 4'd9, 1'b1, 5'd0, "R8");
    do_ins(32'h2000, 2'd0, 8'd3, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 5'd0, "R6");
    do_look(32'h2000, 8'd3, 13'd1, 1'b0, 1'b1, 4'd10, 5'd1, "R6");
    do_look(32'h0010, 8'd3, 13'd1, 1'b0, 1'b1, 4'd9, 5'd2, "R8");

    // R10 clear drops locks; R7 all locked -> last slot, pointer kept
    do_inv();
    do_look(32'h2000, 8'd3, 13'd1, 1'b0, 1'b0, 4'd0, 5'd0, "R10");
    for (int s = 0; s < 16; s++)
      do_ins(32'(s) * 32'h2000, 2'd0, 8'd2, 13'd1, 1'b0, 1'b1, 1'b1, 4'(s), 1'b1, 5'd0, "R8");
    do_ins(32'h0010_0000, 2'd0, 8'd2, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 5'd0, "R7");
    do_look(32'h0010_0000, 8'd2, 13'd1, 1'b0, 1'b1, 4'd15, 5'd1, "R7");
    do_look(32'h0001_e000, 8'd2, 13'd1, 1'b0, 1'b0, 4'd0, 5'd1, "R7");
    do_look(32'h0000_0000, 8'd2, 13'd1, 1'b0, 1'b1, 4'd0, 5'd2, "R8");
    do_inv();
    do_ins(32'h0000_4000, 2'd0, 8'd2, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 5'd0, "R7");
    do_look(32'h0000_4000, 8'd2, 13'd1, 1'b0, 1'b1, 4'd11, 5'd1, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule